// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire serial slave that gives a host controller access to a bank of eighteen 8-bit configuration bytes. It answers to one fixed 7-bit device address and supports four transfer kinds: indexed single-byte write, indexed single-byte read, sequential block write and sequential block read. The command byte that follows the address chooses the kind. When its top bit is set, the transfer touches one byte, and the low seven bits give that byte's offset. When its top bit is clear, the transfer is a block that always starts at offset 0.

The serial clock and data lines arrive unsynchronised. The block resynchronises them to the system clock and finds start and stop conditions and clock edges. It drives the data line only through an open-drain pull-down enable. On the register side it exposes the whole bank as one flat vector and gives a one-cycle strobe for every byte that a write updates. Some bits are read-only: they show a value supplied from outside, such as a vendor code or strap pins latched at power-up. Other bits are status flags that outside logic sets and that software clears by writing a one.

Top module: `smbus_cfg_slave`

## Requirements
- R1: Only an address byte whose upper seven bits equal the device address (default 0x69, so D2h for a write and D3h for a read) is acknowledged. Any other address gets no acknowledge and changes no register.
- R2: A byte write (command bit 7 = 1, bits 6:0 = offset) stores the one data byte at that offset. Every byte of the transfer is acknowledged.
- R3: A byte read (command bit 7 = 1, repeated start, read address) returns the byte at the offset, most significant bit first.
- R4: A block write (command 00h, then a count byte whose value is not used, then data) stores the data bytes at offsets 0, 1, 2 and upwards. A stop after any complete byte ends the transfer, and only the bytes already sent take effect.
- R5: A block read (command 00h, repeated start, read address) first returns the byte count 12h (the number of implemented bytes), then the bytes from offset 0 upwards, until the master does not acknowledge.
- R6: Read-only bits (default: byte 8 bits 3:0 and byte 15 bits 7:3) always show the matching bits of `ro_bits`. Writes to them are ignored.
- R7: A write-1-to-clear bit (default: byte 9 bit 2) is set by a pulse on the matching `w1c_set` bit. Writing 1 to it clears it, and writing 0 leaves it unchanged.
- R8: A write to an offset of 18 or more is acknowledged and discarded, with no strobe. A read from such an offset returns 00h.
- R9: After reset every byte holds its reset value, with read-only bits taken from `ro_bits`. The data line is released and no strobe is active.
- R10: Each accepted in-range data byte raises exactly one `wr_stb` bit for exactly one clock cycle.
- R11: The data line is released in the clock cycle after a stop condition is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line, asynchronous |
| sda_in | input | 1 | Serial data line as seen on the wire, asynchronous |
| ro_bits | input | NUM_BYTES*8 | Values shown in read-only bit positions |
| w1c_set | input | NUM_BYTES*8 | Set pulses for write-1-to-clear bits |
| sda_pull_low | output | 1 | When high, the data line is pulled low |
| cfg_bytes | output | NUM_BYTES*8 | Register contents, byte i at bits i*8+7 down to i*8 |
| wr_stb | output | NUM_BYTES | One-cycle pulse per byte updated by a write |

## Verification
A wrong transfer state or a wrong bit count shows up on the wire first. A missing or misplaced acknowledge, or a read bit shifted by one position, appears within the same serial bit time and is caught by the transfer-level checks. A corrupted byte pointer or write-merge fault shows in `cfg_bytes` within a few system clocks of the stop condition. There the bench compares the whole bank against its model on every idle clock, and it also counts strobes per offset. A register that changes without a strobe or a set pulse is flagged by an assertion one cycle after the change.

// File: rtl/smbus_cfg_pkg.sv
package smbus_cfg_pkg;

    localparam int OFFS_W      = 7;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_WAIT
    } xfer_state_t;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_COUNT,
        PH_DATA
    } xfer_phase_t;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    typedef struct packed {
        logic              en;
        logic [OFFS_W-1:0] offs;
        logic [7:0]        data;
    } reg_wr_t;

    function automatic logic addr_match(input logic [7:0] b, input logic [6:0] dev);
        return b[7:1] == dev;
    endfunction

    function automatic logic [7:0] merge_write(input logic [7:0] cur, input logic [7:0] wdat,
                                               input logic [7:0] ro_m, input logic [7:0] w1c_m);
        logic [7:0] rw_m;
        rw_m = ~ro_m & ~w1c_m;
        return (wdat & rw_m) | (cur & w1c_m & ~wdat);
    endfunction

endpackage

// File: rtl/smbus_line_sync.sv
module smbus_line_sync
    import smbus_cfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);

    logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q;
    logic scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
            scl_q    <= scl_pipe[SYNC_STAGES-1];
            sda_q    <= sda_pipe[SYNC_STAGES-1];
        end
    end

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    always_comb begin
        evt.sda      = sda_s;
        evt.scl_rise = scl_s & ~scl_q;
        evt.scl_fall = ~scl_s & scl_q;
        evt.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/smbus_xfer_ctrl.sv
module smbus_xfer_ctrl
    import smbus_cfg_pkg::*;
#(
    parameter int         NUM_BYTES = 18,
    parameter logic [6:0] DEV_ADDR  = 7'h69
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [7:0]        rd_data,
    output logic [OFFS_W-1:0] rd_offs,
    output reg_wr_t           wr,
    output logic              sda_low
);

    localparam logic [7:0] COUNT_BYTE = 8'(NUM_BYTES);

    xfer_state_t       state;
    xfer_phase_t       phase;
    logic [7:0]        shreg;
    logic [3:0]        bitcnt;
    logic              rw;
    logic              blk;
    logic              count_pend;
    logic [OFFS_W-1:0] ptr;
    logic [7:0]        tx_next;

    assign rd_offs = ptr;
    assign tx_next = count_pend ? COUNT_BYTE : rd_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            phase      <= PH_ADDR;
            shreg      <= '0;
            bitcnt     <= '0;
            rw         <= 1'b0;
            blk        <= 1'b0;
            count_pend <= 1'b0;
            ptr        <= '0;
            sda_low    <= 1'b0;
            wr         <= '0;
        end else begin
            wr.en <= 1'b0;
            if (evt.start) begin
                state   <= ST_RX;
                phase   <= PH_ADDR;
                bitcnt  <= '0;
                sda_low <= 1'b0;
            end else if (evt.stop) begin
                state   <= ST_IDLE;
                sda_low <= 1'b0;
            end else begin
                unique case (state)
                    ST_RX: begin
                        if (evt.scl_rise) begin
                            shreg  <= {shreg[6:0], evt.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (evt.scl_fall && bitcnt == 4'd8) begin
                            state   <= ST_ACK;
                            sda_low <= 1'b1;
                            unique case (phase)
                                PH_ADDR: begin
                                    if (!addr_match(shreg, DEV_ADDR)) begin
                                        state   <= ST_WAIT;
                                        sda_low <= 1'b0;
                                    end else begin
                                        rw <= shreg[0];
                                    end
                                end
                                PH_CMD: begin
                                    blk        <= ~shreg[7];
                                    count_pend <= ~shreg[7];
                                    ptr        <= shreg[7] ? shreg[6:0] : '0;
                                end
                                PH_COUNT: begin
                                end
                                PH_DATA: begin
                                    wr.en   <= 1'b1;
                                    wr.offs <= ptr;
                                    wr.data <= shreg;
                                    ptr     <= ptr + 7'd1;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (evt.scl_fall) begin
                            bitcnt <= '0;
                            if (phase == PH_ADDR && rw) begin
                                state      <= ST_TX;
                                shreg      <= tx_next;
                                sda_low    <= ~tx_next[7];
                                count_pend <= 1'b0;
                                if (!count_pend) ptr <= ptr + 7'd1;
                            end else begin
                                state   <= ST_RX;
                                sda_low <= 1'b0;
                                unique case (phase)
                                    PH_ADDR:  phase <= PH_CMD;
                                    PH_CMD:   phase <= blk ? PH_COUNT : PH_DATA;
                                    PH_COUNT: phase <= PH_DATA;
                                    PH_DATA:  phase <= PH_DATA;
                                endcase
                            end
                        end
                    end
                    ST_TX: begin
                        if (evt.scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (evt.scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                state   <= ST_MACK;
                                sda_low <= 1'b0;
                            end else begin
                                shreg   <= {shreg[6:0], 1'b0};
                                sda_low <= ~shreg[6];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (evt.scl_rise && evt.sda) begin
                            state <= ST_WAIT;
                        end else if (evt.scl_fall) begin
                            state      <= ST_TX;
                            bitcnt     <= '0;
                            shreg      <= tx_next;
                            sda_low    <= ~tx_next[7];
                            count_pend <= 1'b0;
                            if (!count_pend) ptr <= ptr + 7'd1;
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/smbus_cfg_regs.sv
module smbus_cfg_regs
    import smbus_cfg_pkg::*;
#(
    parameter int                       NUM_BYTES = 18,
    parameter logic [NUM_BYTES*8-1:0]   RESET_VAL = '0,
    parameter logic [NUM_BYTES*8-1:0]   RO_MASK   = '0,
    parameter logic [NUM_BYTES*8-1:0]   W1C_MASK  = '0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  reg_wr_t                wr,
    input  logic [NUM_BYTES*8-1:0] ro_bits,
    input  logic [NUM_BYTES*8-1:0] w1c_set,
    output logic [NUM_BYTES*8-1:0] cfg_bytes,
    output logic [NUM_BYTES-1:0]   wr_stb
);

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
        localparam logic [7:0] RO_B  = RO_MASK[i*8 +: 8];
        localparam logic [7:0] W1C_B = W1C_MASK[i*8 +: 8];
        localparam logic [7:0] RST_B = RESET_VAL[i*8 +: 8] & ~RO_MASK[i*8 +: 8];

        logic [7:0] q, nxt;
        logic       hit, stb_q;

        assign hit = wr.en && (wr.offs == OFFS_W'(i));

        always_comb begin
            nxt = q;
            if (hit) nxt = merge_write(q, wr.data, RO_B, W1C_B);
            nxt = nxt | (w1c_set[i*8 +: 8] & W1C_B);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                q     <= RST_B;
                stb_q <= 1'b0;
            end else begin
                q     <= nxt;
                stb_q <= hit;
            end
        end

        assign cfg_bytes[i*8 +: 8] = (q & ~RO_B) | (ro_bits[i*8 +: 8] & RO_B);
        assign wr_stb[i]           = stb_q;
    end

endmodule

// File: rtl/smbus_cfg_slave.sv
module smbus_cfg_slave
    import smbus_cfg_pkg::*;
#(
    parameter int                     NUM_BYTES = 18,
    parameter logic [6:0]             DEV_ADDR  = 7'h69,
    parameter logic [NUM_BYTES*8-1:0] RESET_VAL = {8'h00, 8'h00, 8'h03, 8'h00, 8'h00, 8'h00,
                                                   8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF,
                                                   8'hFF, 8'h00, 8'h7F, 8'hFF, 8'h0F, 8'h00},
    parameter logic [NUM_BYTES*8-1:0] RO_MASK   = {8'h00, 8'h00, 8'hF8, 8'h00, 8'h00, 8'h00,
                                                   8'h00, 8'h00, 8'h00, 8'h0F, 8'h00, 8'h00,
                                                   8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    parameter logic [NUM_BYTES*8-1:0] W1C_MASK  = {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
                                                   8'h00, 8'h00, 8'h04, 8'h00, 8'h00, 8'h00,
                                                   8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_in,
    input  logic                   sda_in,
    input  logic [NUM_BYTES*8-1:0] ro_bits,
    input  logic [NUM_BYTES*8-1:0] w1c_set,
    output logic                   sda_pull_low,
    output logic [NUM_BYTES*8-1:0] cfg_bytes,
    output logic [NUM_BYTES-1:0]   wr_stb
);

    bus_evt_t          evt;
    reg_wr_t           wr_req;
    logic [OFFS_W-1:0] rd_offs;
    logic [7:0]        rd_data;

    smbus_line_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    smbus_xfer_ctrl #(
        .NUM_BYTES (NUM_BYTES),
        .DEV_ADDR  (DEV_ADDR)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .rd_data (rd_data),
        .rd_offs (rd_offs),
        .wr      (wr_req),
        .sda_low (sda_pull_low)
    );

    smbus_cfg_regs #(
        .NUM_BYTES (NUM_BYTES),
        .RESET_VAL (RESET_VAL),
        .RO_MASK   (RO_MASK),
        .W1C_MASK  (W1C_MASK)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr_req),
        .ro_bits   (ro_bits),
        .w1c_set   (w1c_set),
        .cfg_bytes (cfg_bytes),
        .wr_stb    (wr_stb)
    );

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (rd_offs == OFFS_W'(i)) rd_data = cfg_bytes[i*8 +: 8];
        end
    end

endmodule

// File: rtl/smbus_cfg_slave_chk.sv
module smbus_cfg_slave_chk #(
    parameter int                     NUM_BYTES = 18,
    parameter logic [NUM_BYTES*8-1:0] RO_MASK   = '0
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   sda_pull_low,
    input logic [NUM_BYTES*8-1:0] cfg_bytes,
    input logic [NUM_BYTES-1:0]   wr_stb,
    input logic [NUM_BYTES*8-1:0] w1c_set,
    input logic                   stop_seen
);

    // R10: at most one byte strobed at a time
    p_stb_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_stb));

    // R10: a strobe lasts exactly one cycle
    p_stb_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_stb != '0) |=> (wr_stb == '0));

    // R11: line released after stop
    p_stop_release_r11: assert property (@(posedge clk) disable iff (rst)
        stop_seen |=> !sda_pull_low);

    // R9: state right after reset release
    p_reset_quiet_r9: assert property (@(posedge clk)
        $fell(rst) |-> (wr_stb == '0 && !sda_pull_low));

    // R7 / R10: writable content changes only with a strobe or a set pulse
    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_hold
        localparam logic [7:0] RW_B = ~RO_MASK[i*8 +: 8];
        p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
            ((cfg_bytes[i*8 +: 8] & RW_B) != ($past(cfg_bytes[i*8 +: 8]) & RW_B))
            |-> (wr_stb[i] || $past(|w1c_set[i*8 +: 8])));
    end

endmodule

bind smbus_cfg_slave smbus_cfg_slave_chk #(
    .NUM_BYTES (NUM_BYTES),
    .RO_MASK   (RO_MASK)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .sda_pull_low (sda_pull_low),
    .cfg_bytes    (cfg_bytes),
    .wr_stb       (wr_stb),
    .w1c_set      (w1c_set),
    .stop_seen    (evt.stop)
);

// File: tb/smbus_cfg_slave_tb_top.sv
`timescale 1ns/1ps
module smbus_cfg_slave_tb_top;

    localparam int NB = 18;
    localparam int Q  = 8;
    localparam logic [6:0] DEV = 7'h69;
    localparam logic [NB*8-1:0] RV  = {8'h00, 8'h00, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
                                       8'h00, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h7F, 8'hFF, 8'h0F, 8'h00};
    localparam logic [NB*8-1:0] ROM = {8'h00, 8'h00, 8'hF8, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
                                       8'h0F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    localparam logic [NB*8-1:0] W1M = {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h04,
                                       8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    localparam logic [NB*8-1:0] ROV = {8'h00, 8'h00, 8'hA8, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
                                       8'h02, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic [NB*8-1:0] w1c_set = '0;
    logic sda_pull_low;
    logic [NB*8-1:0] cfg_bytes;
    logic [NB-1:0] wr_stb;
    wire sda_bus = sda_m & ~sda_pull_low;

    always #2 clk = ~clk;

    smbus_cfg_slave #(
        .NUM_BYTES (NB), .DEV_ADDR (DEV), .RESET_VAL (RV), .RO_MASK (ROM), .W1C_MASK (W1M)
    ) dut_i (
        .clk (clk), .rst (rst), .scl_in (scl), .sda_in (sda_bus),
        .ro_bits (ROV), .w1c_set (w1c_set),
        .sda_pull_low (sda_pull_low), .cfg_bytes (cfg_bytes), .wr_stb (wr_stb)
    );

    int checks = 0, errors = 0;
    int mon_checks = 0, mon_errors = 0;
    int stb_cnt [NB];
    int exp_stb [NB];
    logic [7:0] mdl [NB];
    logic cmp_en = 1'b0;

    function automatic logic [NB*8-1:0] exp_cfg();
        logic [NB*8-1:0] r;
        for (int i = 0; i < NB; i++)
            r[i*8 +: 8] = (mdl[i] & ~ROM[i*8 +: 8]) | (ROV[i*8 +: 8] & ROM[i*8 +: 8]);
        return r;
    endfunction

    // per-clock comparison of the register bank against the model while the bus is idle
    initial for (int i = 0; i < NB; i++) stb_cnt[i] = 0;
    always @(negedge clk) begin
        for (int i = 0; i < NB; i++) if (wr_stb[i]) stb_cnt[i] = stb_cnt[i] + 1;
        if (cmp_en) begin
            mon_checks = mon_checks + 1;
            if (cfg_bytes !== exp_cfg() || wr_stb !== '0 || sda_pull_low !== 1'b0) begin
                mon_errors = mon_errors + 1;
                if (mon_errors < 10)
                    $display("FAIL R9/R2 idle bank: actual %h expected %h (stb %h sda %b)",
                             cfg_bytes, exp_cfg(), wr_stb, sda_pull_low);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors",
                 checks + mon_checks + 1, errors + mon_errors + 1);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        wq(); sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0;
    endtask

    task automatic bus_stop();
        wq(); sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int k = 7; k >= 0; k--) begin
            wq(); sda_m = b[k]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0;
        end
        wq(); sda_m = 1'b1; wq(); scl = 1'b1; wq(); ack = ~sda_bus; wq(); scl = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic nack);
        d = '0;
        for (int k = 0; k < 8; k++) begin
            wq(); sda_m = 1'b1; wq(); scl = 1'b1; wq(); d = {d[6:0], sda_bus}; wq(); scl = 1'b0;
        end
        wq(); sda_m = nack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0;
    endtask

    task automatic mdl_write(input int off, input logic [7:0] d);
        logic [7:0] ro, w1;
        if (off < NB) begin
            ro = ROM[off*8 +: 8];
            w1 = W1M[off*8 +: 8];
            mdl[off] = (d & ~ro & ~w1) | (mdl[off] & w1 & ~d);
            exp_stb[off]++;
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
        cmp_en = 1'b1;
    endtask

    task automatic check_strobes(input string req);
        for (int i = 0; i < NB; i++) chk(req, stb_cnt[i], exp_stb[i]);
    endtask

    task automatic byte_write(input int off, input logic [7:0] d, input string req);
        logic a;
        cmp_en = 1'b0;
        bus_start();
        send_byte({DEV, 1'b0}, a); chk({req, " addr ack"}, a, 1);
        send_byte(8'h80 | 8'(off), a); chk({req, " cmd ack"}, a, 1);
        send_byte(d, a); chk({req, " data ack"}, a, 1);
        bus_stop();
        mdl_write(off, d);
        settle();
    endtask

    task automatic byte_read(input int off, output logic [7:0] d);
        logic a;
        cmp_en = 1'b0;
        bus_start();
        send_byte({DEV, 1'b0}, a); chk("R3 addr ack", a, 1);
        send_byte(8'h80 | 8'(off), a); chk("R3 cmd ack", a, 1);
        bus_start();
        send_byte({DEV, 1'b1}, a); chk("R3 read addr ack", a, 1);
        recv_byte(d, 1'b1);
        bus_stop();
        settle();
    endtask

    task automatic block_write(input int cnt, input int sent, input logic [7:0] base);
        logic a;
        cmp_en = 1'b0;
        bus_start();
        send_byte({DEV, 1'b0}, a); chk("R4 addr ack", a, 1);
        send_byte(8'h00, a); chk("R4 cmd ack", a, 1);
        send_byte(8'(cnt), a); chk("R4 count ack", a, 1);
        for (int i = 0; i < sent; i++) begin
            send_byte(base + 8'(i * 17), a); chk("R4 data ack", a, 1);
            mdl_write(i, base + 8'(i * 17));
        end
        bus_stop();
        settle();
    endtask

    task automatic block_read(input int n);
        logic a;
        logic [7:0] d;
        cmp_en = 1'b0;
        bus_start();
        send_byte({DEV, 1'b0}, a); chk("R5 addr ack", a, 1);
        send_byte(8'h00, a); chk("R5 cmd ack", a, 1);
        bus_start();
        send_byte({DEV, 1'b1}, a); chk("R5 read addr ack", a, 1);
        recv_byte(d, 1'b0); chk("R5 byte count", d, 8'h12);
        for (int i = 0; i < n; i++) begin
            recv_byte(d, i == n - 1);
            if (i < NB) chk("R5 block data", d, exp_cfg() >> (i * 8) & 8'hFF);
            else        chk("R8 block data past end", d, 8'h00);
        end
        bus_stop();
        settle();
    endtask

    initial begin
        logic [7:0] d;
        logic a;
        for (int i = 0; i < NB; i++) begin
            mdl[i] = RV[i*8 +: 8];
            exp_stb[i] = 0;
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset contents and quiet outputs
        chk("R9 reset bank", cfg_bytes == exp_cfg(), 1);
        chk("R9 reset sda", sda_pull_low, 0);
        chk("R9 reset strobes", wr_stb, 0);
        settle();

        // R3: read reset value
        byte_read(2, d); chk("R3 read offset 2", d, 8'hFF);
        byte_read(1, d); chk("R3 read offset 1", d, 8'h0F);

        // R2 / R10: byte write and strobe
        byte_write(3, 8'hA5, "R2");
        check_strobes("R10 strobe after byte write");
        byte_read(3, d); chk("R3 read back offset 3", d, 8'hA5);
        byte_write(17, 8'h3C, "R2");
        byte_read(17, d); chk("R3 read back offset 17", d, 8'h3C);

        // R1: foreign address ignored
        cmp_en = 1'b0;
        bus_start();
        send_byte({7'h55, 1'b0}, a); chk("R1 foreign address nack", a, 0);
        send_byte(8'h83, a); chk("R1 no ack after foreign address", a, 0);
        send_byte(8'h11, a);
        bus_stop();
        settle();
        cmp_en = 1'b0;
        bus_start();
        send_byte({7'h68, 1'b1}, a); chk("R1 neighbour address nack", a, 0);
        bus_stop();
        settle();
        check_strobes("R1 no strobe for foreign address");

        // R4: full and truncated block writes
        block_write(5, 5, 8'h21);
        check_strobes("R4 strobes after block write");
        block_write(5, 2, 8'hC0);
        check_strobes("R4 strobes after truncated block write");

        // R5 / R8: block read including past the end
        block_read(4);
        block_read(NB + 1);

        // R6: read-only bits
        byte_write(8, 8'hFF, "R6");
        byte_read(8, d); chk("R6 vendor nibble kept", d, 8'hF2);
        byte_write(15, 8'h00, "R6");
        byte_read(15, d); chk("R6 strap bits kept", d, 8'hA8);

        // R7: write-1-to-clear
        byte_write(9, 8'h30, "R7");
        cmp_en = 1'b0;
        @(negedge clk); w1c_set[9*8 + 2] = 1'b1;
        @(negedge clk); w1c_set = '0; mdl[9] = mdl[9] | 8'h04;
        settle();
        byte_read(9, d); chk("R7 status set", d, 8'h34);
        byte_write(9, 8'h30, "R7");
        byte_read(9, d); chk("R7 write 0 keeps status", d, 8'h34);
        byte_write(9, 8'h04, "R7");
        byte_read(9, d); chk("R7 write 1 clears status", d, 8'h00);

        // R8: out of range
        byte_write(8'h30, 8'h55, "R8");
        check_strobes("R8 no strobe out of range");
        byte_read(8'h30, d); chk("R8 read out of range", d, 8'h00);
        byte_read(NB, d); chk("R8 read first offset past end", d, 8'h00);

        // R11: line released after stop
        chk("R11 released after stop", sda_pull_low, 0);

        cmp_en = 1'b0;
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors",
                 checks + mon_checks, errors + mon_errors);
        $finish;
    end

endmodule